// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the read-only status byte of a serial port's modem-control section. The high nibble shows the present levels of four modem inputs: carrier detect, ring, data-set-ready and clear-to-send. The low nibble holds four sticky change flags. Three of the flags record a change in either direction. The ring flag records only a high-to-low transition. While any flag is set and the status interrupt is enabled, the block asserts an interrupt event.

The inputs can come from two places. Normally they are the external pins, passed through a synchronizer. With loopback enabled they are taken from four modem-control output bits, and the pins are ignored. While the port runs an infrared mode, a status-select bit can replace the whole byte with the constant 0x30. The flags are cleared by reset, by a read strobe, and by a change of operating mode. The mode-change clear does not happen while the select bit is 1.

Top module: `modem_status_reg`

## Requirements
- R1: The read byte carries {DCD, RI, DSR, CTS} in bits 7 to 4 and the flags {DDCD, TERI, DDSR, DCTS} in bits 3 to 0. After reset the flags read 0 and stay 0 through the SYNC_STAGES+1 warm-up cycles. After that, bits 7 to 4 equal the input levels.
- R2: DCTS (bit 0), DDSR (bit 1) and DDCD (bit 3) are set when CTS, DSR or DCD change in either direction. Each stays set until it is cleared.
- R3: TERI (bit 2) is set when RI falls from 1 to 0. A rising RI leaves it unchanged.
- R4: When `rd_stb` is high for a cycle, `rd_data` shows the value from before the clear. Bits 3 to 0 are cleared at the next clock edge.
- R5: A change detected in the same cycle as a clear leaves its flag set after that edge.
- R6: A change of `op_mode` clears bits 3 to 0 when `ir_stat_sel` is 0. It leaves them unchanged when `ir_stat_sel` is 1.
- R7: With `ir_mode` = 1 and `ir_stat_sel` = 1, `rd_data` reads 0x30 whatever the inputs are. With `ir_stat_sel` = 0, it reads as in R1.
- R8: With `lb_en` = 1, the status inputs are mapped as mc_dtr to DSR, mc_rts to CTS, mc_out1 to RI and mc_out2 to DCD. A looped value is seen one edge after it changes, and the pins have no effect.
- R9: Entering or leaving loopback sets a flag only for a line whose new source differs from its last level.
- R10: `ms_event` is 1 exactly when `ms_ie` is 1 and any flag is set.
- R11: A pin change appears in `rd_data` after SYNC_STAGES+1 clock edges, and not after SYNC_STAGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cts | input | 1 | Clear-to-send pin (asynchronous) |
| pin_dsr | input | 1 | Data-set-ready pin (asynchronous) |
| pin_ri | input | 1 | Ring pin (asynchronous) |
| pin_dcd | input | 1 | Carrier-detect pin (asynchronous) |
| lb_en | input | 1 | Loopback enable |
| mc_dtr | input | 1 | Modem-control DTR bit, looped to DSR |
| mc_rts | input | 1 | Modem-control RTS bit, looped to CTS |
| mc_out1 | input | 1 | Modem-control OUT1 bit, looped to RI |
| mc_out2 | input | 1 | Modem-control OUT2 bit, looped to DCD |
| op_mode | input | MODE_W | Operating-mode code; any change is a mode change |
| ir_mode | input | 1 | High while the mode is an infrared mode |
| ir_stat_sel | input | 1 | Infrared status select |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| ms_ie | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Register read value |
| ms_event | output | 1 | Modem-status interrupt event |

## Verification
The bench uses the defaults: SYNC_STAGES = 2, MODE_W = 2 and IR_READBACK = 0x30. With these values the R11 latency test can check the exact cycle, two edges empty and the third showing the change. Loopback stimulus has a one-edge path, so a read strobe and a new change can be placed on the same edge. Several mode codes are available, so a mode change can be made both with and without the status-select bit.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // index of each line in the level nibble; the flag of a line shares its index
  localparam int unsigned IX_CTS = 0;
  localparam int unsigned IX_DSR = 1;
  localparam int unsigned IX_RI  = 2;
  localparam int unsigned IX_DCD = 3;
  localparam int unsigned NLINE  = 4;

  typedef logic [NLINE-1:0] line_t;

  // loopback routing of modem-control bits onto the status lines
  function automatic line_t loop_map(input logic dtr, input logic rts,
                                     input logic out1, input logic out2);
    line_t r;
    r[IX_CTS] = rts;
    r[IX_DSR] = dtr;
    r[IX_RI]  = out1;
    r[IX_DCD] = out2;
    return r;
  endfunction

  // change events between the stored level and the new source
  function automatic line_t change_flags(input line_t prev, input line_t cur);
    line_t r;
    r[IX_CTS] = prev[IX_CTS] ^ cur[IX_CTS];
    r[IX_DSR] = prev[IX_DSR] ^ cur[IX_DSR];
    r[IX_RI]  = prev[IX_RI] & ~cur[IX_RI];
    r[IX_DCD] = prev[IX_DCD] ^ cur[IX_DCD];
    return r;
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel (
  input  logic          lb_en,
  input  msr_pkg::line_t synced,
  input  logic          mc_dtr,
  input  logic          mc_rts,
  input  logic          mc_out1,
  input  logic          mc_out2,
  output msr_pkg::line_t src
);
  msr_pkg::line_t looped;

  assign looped = msr_pkg::loop_map(mc_dtr, mc_rts, mc_out1, mc_out2);

  always_comb begin
    if (lb_en) src = looped;
    else       src = synced;
  end
endmodule

// File: rtl/msr_track.sv
module msr_track #(
  parameter int unsigned WARM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  msr_pkg::line_t src,
  input  logic           clr_req,
  output msr_pkg::line_t lvl_q,
  output msr_pkg::line_t flags_q,
  output msr_pkg::line_t edge_ev,
  output logic           warm_done
);
  localparam int unsigned CW = $clog2(WARM + 1);

  logic [CW-1:0] warm_cnt;

  assign warm_done = (warm_cnt == CW'(WARM));
  assign edge_ev   = warm_done ? msr_pkg::change_flags(lvl_q, src) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      flags_q  <= '0;
      warm_cnt <= '0;
    end else begin
      lvl_q <= src;
      if (!warm_done) begin
        warm_cnt <= warm_cnt + CW'(1);
        flags_q  <= '0;
      end else begin
        flags_q <= (clr_req ? '0 : flags_q) | edge_ev;
      end
    end
  end

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && edge_ev == '0) |=> flags_q == '0);

  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> (flags_q & $past(flags_q)) == $past(flags_q));

  a_r5_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev != '0) |=> (flags_q & $past(edge_ev)) == $past(edge_ev));

  a_r3_teri_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[msr_pkg::IX_RI]) |-> ($past(lvl_q[msr_pkg::IX_RI]) && !lvl_q[msr_pkg::IX_RI]));

  a_r1_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> flags_q == '0);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_W      = 2,
  parameter logic [7:0]  IR_READBACK = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              pin_ri,
  input  logic              pin_dcd,
  input  logic              lb_en,
  input  logic              mc_dtr,
  input  logic              mc_rts,
  input  logic              mc_out1,
  input  logic              mc_out2,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              ir_mode,
  input  logic              ir_stat_sel,
  input  logic              rd_stb,
  input  logic              ms_ie,
  output logic [7:0]        rd_data,
  output logic              ms_event
);
  localparam int unsigned WARM = SYNC_STAGES + 1;

  msr_pkg::line_t pins, synced, src, lvl_q, flags_q, edge_ev;
  logic [MODE_W-1:0] mode_q;
  logic mode_chg, clr_req, fixed_rd, warm_done;

  always_comb begin
    pins = '0;
    pins[msr_pkg::IX_CTS] = pin_cts;
    pins[msr_pkg::IX_DSR] = pin_dsr;
    pins[msr_pkg::IX_RI]  = pin_ri;
    pins[msr_pkg::IX_DCD] = pin_dcd;
  end

  msr_sync #(.W(msr_pkg::NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins), .dout(synced)
  );

  msr_src_sel u_sel (
    .lb_en(lb_en), .synced(synced), .mc_dtr(mc_dtr), .mc_rts(mc_rts),
    .mc_out1(mc_out1), .mc_out2(mc_out2), .src(src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= op_mode;
  end

  assign mode_chg = (op_mode != mode_q);
  assign clr_req  = rd_stb | (mode_chg & ~ir_stat_sel);

  msr_track #(.WARM(WARM)) u_track (
    .clk(clk), .rst_n(rst_n), .src(src), .clr_req(clr_req),
    .lvl_q(lvl_q), .flags_q(flags_q), .edge_ev(edge_ev), .warm_done(warm_done)
  );

  assign fixed_rd = ir_mode & ir_stat_sel;
  assign rd_data  = fixed_rd ? IR_READBACK : {lvl_q, flags_q};
  assign ms_event = ms_ie & (|flags_q);

  a_r7_fixed_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && ir_stat_sel) |-> rd_data == IR_READBACK);

  a_r10_event_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ms_event |-> ms_ie);

  a_r10_event_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_ie && !fixed_rd && rd_data[3:0] != 4'h0) |-> ms_event);

  a_r6_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !ir_stat_sel && edge_ev == '0) |=> flags_q == '0);

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && ir_stat_sel && !rd_stb && warm_done) |=> (flags_q & $past(flags_q)) == $past(flags_q));
endmodule

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
  logic lb_en = 0, mc_dtr = 0, mc_rts = 0, mc_out1 = 0, mc_out2 = 0;
  logic [1:0] op_mode = 2'd0;
  logic ir_mode = 0, ir_stat_sel = 0, rd_stb = 0, ms_ie = 0;
  logic [7:0] rd_data;
  logic ms_event;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_status_reg dut (
    .clk(clk), .rst_n(rst_n), .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri),
    .pin_dcd(pin_dcd), .lb_en(lb_en), .mc_dtr(mc_dtr), .mc_rts(mc_rts),
    .mc_out1(mc_out1), .mc_out2(mc_out2), .op_mode(op_mode), .ir_mode(ir_mode),
    .ir_stat_sel(ir_stat_sel), .rd_stb(rd_stb), .ms_ie(ms_ie),
    .rd_data(rd_data), .ms_event(ms_event)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic peek(input string tag, input logic [7:0] exp);
    #1 chk(tag, rd_data, exp);
  endtask

  task automatic rd(input string tag, input logic [7:0] exp);
    rd_stb = 1'b1;
    #1 chk(tag, rd_data, exp);
    tick(1);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    pin_cts = 1; pin_ri = 1; ms_ie = 1;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    peek("R1 warm-up flags quiet", 8'h00);
    tick(4);
    peek("R1 levels after reset", 8'h50);
    chk("R10 no event after reset", {7'd0, ms_event}, 8'h00);
  endtask

  task automatic t_sync_latency;
    pin_cts = 0;
    tick(2);
    peek("R11 not visible after 2 edges", 8'h50);
    tick(1);
    peek("R11 R2 visible after 3 edges", 8'h41);
    chk("R10 event with enable", {7'd0, ms_event}, 8'h01);
    ms_ie = 0;
    #1 chk("R10 no event without enable", {7'd0, ms_event}, 8'h00);
    ms_ie = 1;
    rd("R4 read returns pre-clear", 8'h41);
    peek("R4 flags cleared", 8'h40);
    chk("R10 event drops after read", {7'd0, ms_event}, 8'h00);
  endtask

  task automatic t_deltas;
    pin_dsr = 1; pin_dcd = 1;
    tick(4);
    peek("R2 rising DSR and DCD", 8'hEA);
    rd("R4 read", 8'hEA);
    pin_dsr = 0;
    tick(4);
    peek("R2 falling DSR", 8'hC2);
    rd("R4 read", 8'hC2);
  endtask

  task automatic t_teri;
    pin_ri = 0;
    tick(4);
    peek("R3 falling RI sets TERI", 8'h84);
    rd("R4 read", 8'h84);
    pin_ri = 1;
    tick(4);
    peek("R3 rising RI no flag", 8'hC0);
  endtask

  task automatic t_mode;
    pin_cts = 1;
    tick(4);
    peek("R2 CTS rise", 8'hD1);
    op_mode = 2'd1;
    tick(1);
    peek("R6 mode change clears", 8'hD0);
    pin_cts = 0;
    tick(4);
    peek("R2 CTS fall", 8'hC1);
    ir_stat_sel = 1; op_mode = 2'd2;
    tick(1);
    peek("R6 mode change held by select", 8'hC1);
  endtask

  task automatic t_ir;
    ir_mode = 1;
    tick(1);
    peek("R7 fixed readback", 8'h30);
    pin_cts = 1;
    tick(4);
    peek("R7 fixed ignores inputs", 8'h30);
    ir_stat_sel = 0;
    tick(1);
    peek("R7 select 0 normal", 8'hD1);
    rd("R4 read", 8'hD1);
    ir_mode = 0;
    peek("R7 cleared", 8'hD0);
  endtask

  task automatic t_loop;
    mc_out2 = 1; mc_out1 = 1; mc_dtr = 0; mc_rts = 1;
    lb_en = 1;
    tick(1);
    peek("R9 equal source no delta", 8'hD0);
    pin_cts = 0;
    tick(4);
    peek("R8 pins ignored", 8'hD0);
    mc_dtr = 1;
    tick(1);
    peek("R8 looped DTR to DSR", 8'hF2);
    rd("R4 read", 8'hF2);
    lb_en = 0;
    tick(1);
    peek("R9 leaving loopback real diff", 8'hC3);
    rd("R4 read", 8'hC3);
  endtask

  task automatic t_same_cycle;
    lb_en = 1;
    tick(1);
    peek("R8 loop re-enter", 8'hF3);
    rd("R4 read", 8'hF3);
    mc_out2 = 0;
    tick(1);
    peek("R8 looped OUT2 to DCD", 8'h78);
    mc_rts = 0;
    rd("R5 read value before clear", 8'h78);
    peek("R5 new edge survives clear", 8'h61);
  endtask

  initial begin
    t_reset();
    t_sync_latency();
    t_deltas();
    t_teri();
    t_mode();
    t_ir();
    t_loop();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule